// File: doc/BRIEF.md
# Shared-ALU Register File Datapath

This block is a small execution datapath: seven general-purpose registers share a single arithmetic/logic unit. Two operand selectors each pick one register, or an external data input, and place it on operand bus A or bus B. The ALU combines the two buses. A destination decoder then steers the result into at most one register on the next rising clock edge.

Each cycle, a 14-bit control word performs exactly one register-transfer step. Examples are "R1 gets R2 minus R3" and "R4 gets R4 shifted left". A sequencer outside the block drives the control word and the external data. The block returns the ALU result combinationally, together with read-back taps of all seven registers. The data width is a parameter with a default of 8 bits.

Top module: `regdp_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, all seven registers clear to zero. `rst` is synchronous and active high.
- R2: The control word is packed as follows: bits [13:11] select operand A, bits [10:8] select operand B, bits [7:5] select the destination, and bits [4:0] hold the ALU opcode.
- R3: A source select code from 1 to 7 places register Rn on its bus. Code 0 places `ext_in` on the bus. This holds for both bus A and bus B.
- R4: A legal opcode with a destination code n from 1 to 7 loads `result` into Rn at the next rising edge. All other registers keep their values.
- R5: Destination code 0 loads no register. The result is visible only on `result`.
- R6: Arithmetic opcodes: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A−B, and 00110 gives A−1. All results wrap modulo 2^WIDTH.
- R7: Logic opcodes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A.
- R8: Opcode 10000 shifts A right by one bit and opcode 11000 shifts A left by one bit. In both cases the vacated bit is filled with 0.
- R9: Any other opcode drives `result` to zero and leaves every register unchanged, whatever the destination code.
- R10: Operands are read combinationally in the current cycle. A register can therefore be a source and the destination in the same step, and it receives a value computed from its old contents.
- R11: `reg_taps` carries R1 in bits [WIDTH-1:0], R2 in the next WIDTH bits, and so on up to R7 in the top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Packed microoperation: A select, B select, destination, opcode |
| ext_in | input | WIDTH | External data, selected by source code 0 |
| result | output | WIDTH | Combinational ALU output for the current control word |
| reg_taps | output | 7*WIDTH | Current contents of R1..R7, with R1 in the lowest slice |

## Verification
The assertions assume that `ctrl_word` and `ext_in` are settled before each rising edge and hold no unknown bits while `rst` is low. They also assume `rst` is high from time zero, so the first sampled cycles come after a defined reset. The stimulus meets these assumptions by changing inputs only on the falling clock edge and by holding reset for several cycles at the start. It also applies a second reset mid-run and drives every opcode and select code only with fully defined values. The stimulus covers the illegal-opcode and no-destination cases using nonzero destination and operand codes, so that a stray write would show up on the taps.

// File: rtl/regdp_pkg.sv
package regdp_pkg;

    localparam int NUM_REGS  = 7;
    localparam int SEL_W     = 3;
    localparam int OP_W      = 5;
    localparam int CTRL_W    = 3 * SEL_W + OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    // Field order is behaviour: bits [13:11] A, [10:8] B, [7:5] dest, [4:0] op
    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } ctrl_t;

    function automatic logic op_is_known(input logic [OP_W-1:0] code);
        case (code)
            OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC,
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/regdp_srcmux.sv
module regdp_srcmux
    import regdp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int NREG  = NUM_REGS
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [WIDTH-1:0] ext_data,
    input  logic [WIDTH-1:0] regs [NREG],
    output logic [WIDTH-1:0] operand
);
    always_comb begin
        operand = ext_data;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i + 1)) operand = regs[i];
        end
    end
endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
    import regdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             legal
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        legal = 1'b1;
        case (alu_op_e'(op))
            OP_PASS: y = a;
            OP_INC:  y = a + ONE;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_DEC:  y = a - ONE;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHR:  y = {1'b0, a[WIDTH-1:1]};
            OP_SHL:  y = {a[WIDTH-2:0], 1'b0};
            default: begin
                y     = '0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regdp_destdec.sv
module regdp_destdec
    import regdp_pkg::*;
#(
    parameter int NREG = NUM_REGS
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             enable,
    output logic [NREG-1:0]  load_en
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign load_en[i] = enable && (sel == SEL_W'(i + 1));
    end
endmodule

// File: rtl/regdp_regbank.sv
module regdp_regbank
    import regdp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int NREG  = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  load_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] regs [NREG]
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)             regs[i] <= '0;
            else if (load_en[i]) regs[i] <= wdata;
        end

        // R4
        write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            load_en[i] |=> regs[i] == $past(wdata));

        // R4
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            !load_en[i] |=> $stable(regs[i]));

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> regs[i] == '0);
    end
endmodule

// File: rtl/regdp_core.sv
module regdp_core
    import regdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CTRL_W-1:0]         ctrl_word,
    input  logic [WIDTH-1:0]          ext_in,
    output logic [WIDTH-1:0]          result,
    output logic [NUM_REGS*WIDTH-1:0] reg_taps
);
    ctrl_t            ctl;
    logic [WIDTH-1:0] bus_a, bus_b, alu_y;
    logic             alu_legal;
    logic [NUM_REGS-1:0] load_en;
    logic [WIDTH-1:0] regs [NUM_REGS];

    assign ctl = ctrl_t'(ctrl_word);

    regdp_srcmux #(.WIDTH(WIDTH), .NREG(NUM_REGS)) u_mux_a (
        .sel(ctl.src_a), .ext_data(ext_in), .regs(regs), .operand(bus_a));

    regdp_srcmux #(.WIDTH(WIDTH), .NREG(NUM_REGS)) u_mux_b (
        .sel(ctl.src_b), .ext_data(ext_in), .regs(regs), .operand(bus_b));

    regdp_alu #(.WIDTH(WIDTH)) u_alu (
        .op(ctl.op), .a(bus_a), .b(bus_b), .y(alu_y), .legal(alu_legal));

    regdp_destdec #(.NREG(NUM_REGS)) u_dec (
        .sel(ctl.dst), .enable(alu_legal), .load_en(load_en));

    regdp_regbank #(.WIDTH(WIDTH), .NREG(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .load_en(load_en), .wdata(alu_y), .regs(regs));

    assign result = alu_y;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_tap
        assign reg_taps[i*WIDTH +: WIDTH] = regs[i];
    end

    // R9
    unknown_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_is_known(ctl.op) |=> $stable(reg_taps));

    // R9
    unknown_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !op_is_known(ctl.op) |-> result == '0);

    // R5
    no_dest_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.dst == '0 |=> $stable(reg_taps));

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_en));
endmodule

// File: tb/regdp_core_test.sv
module regdp_core_test;
    localparam int W = 8;

    typedef struct {
        string        req;
        logic [W-1:0] exp_res;
        logic [7*W-1:0] exp_taps;
    } item_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [13:0]    ctrl_word = '0;
    logic [W-1:0]   ext_in = '0;
    logic [W-1:0]   result;
    logic [7*W-1:0] reg_taps;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] model [1:7];
    item_t sb_q [$];
    event chk_ev;

    always #4 clk = ~clk;

    regdp_core #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
        .result(result), .reg_taps(reg_taps));

    function automatic logic known(input logic [4:0] op);
        return op inside {5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                          5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
    endfunction

    function automatic logic [W-1:0] ref_alu(input logic [4:0] op,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            5'b00000: return a;
            5'b00001: return a + 8'd1;
            5'b00010: return a + b;
            5'b00101: return a - b;
            5'b00110: return a - 8'd1;
            5'b01000: return a & b;
            5'b01010: return a | b;
            5'b01100: return a ^ b;
            5'b01110: return ~a;
            5'b10000: return a >> 1;
            5'b11000: return a << 1;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [7*W-1:0] pack_model();
        logic [7*W-1:0] t;
        for (int i = 1; i <= 7; i++) t[(i-1)*W +: W] = model[i];
        return t;
    endfunction

    task automatic run(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                       input logic [4:0] op, input logic [W-1:0] ext, input string req);
        item_t it;
        logic [W-1:0] av, bv;
        @(negedge clk);
        ctrl_word = {sa, sb, sd, op};
        ext_in    = ext;
        av = (sa == 3'd0) ? ext : model[sa];
        bv = (sb == 3'd0) ? ext : model[sb];
        it.req      = req;
        it.exp_res  = ref_alu(op, av, bv);
        it.exp_taps = pack_model();
        sb_q.push_back(it);
        #1 -> chk_ev;
        if (sd != 3'd0 && known(op)) model[sd] = it.exp_res;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (result !== it.exp_res) begin
                    errors++;
                    $display("FAIL %s result: got %h expected %h", it.req, result, it.exp_res);
                end
                checks++;
                if (reg_taps !== it.exp_taps) begin
                    errors++;
                    $display("FAIL %s taps: got %h expected %h", it.req, reg_taps, it.exp_taps);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        for (int i = 1; i <= 7; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: taps all zero after reset
        run(3'd0, 3'd0, 3'd0, 5'b00000, 8'h5A, "R1");
        // R3 / R11: load every register from ext_in (code 0 on bus A)
        for (int i = 1; i <= 7; i++)
            run(3'd0, 3'd0, 3'(i), 5'b00000, 8'(8'h10 * i + 3), "R3");
        // R2: word 010 011 001 00101 gives R1 = R2 - R3
        run(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, "R2");
        // R2 / R10: word 100 000 100 11000 shifts R4 left in place
        run(3'd4, 3'd0, 3'd4, 5'b11000, 8'hFF, "R10");
        // R6 arithmetic with B from ext_in
        run(3'd5, 3'd0, 3'd6, 5'b00010, 8'hC7, "R6");
        run(3'd7, 3'd2, 3'd7, 5'b00101, 8'h00, "R6");
        run(3'd0, 3'd0, 3'd2, 5'b00000, 8'hFF, "R6");
        run(3'd2, 3'd0, 3'd2, 5'b00001, 8'h00, "R6");   // 0xFF+1 wraps to 0
        run(3'd2, 3'd0, 3'd3, 5'b00110, 8'h00, "R6");   // 0-1 wraps to 0xFF
        // R7 logic
        run(3'd5, 3'd6, 3'd1, 5'b01000, 8'h00, "R7");
        run(3'd5, 3'd6, 3'd0, 5'b01010, 8'h00, "R7");
        run(3'd5, 3'd0, 3'd7, 5'b01100, 8'hA5, "R7");
        run(3'd7, 3'd0, 3'd7, 5'b01110, 8'h00, "R7");
        // R8 shifts, zero fill
        run(3'd0, 3'd0, 3'd5, 5'b00000, 8'h81, "R8");
        run(3'd5, 3'd0, 3'd4, 5'b10000, 8'h00, "R8");
        run(3'd5, 3'd0, 3'd5, 5'b11000, 8'h00, "R8");
        // R5: no destination, result only on port
        run(3'd3, 3'd1, 3'd0, 5'b00010, 8'h00, "R5");
        run(3'd6, 3'd0, 3'd0, 5'b01110, 8'h00, "R5");
        // R9: unknown opcodes, nonzero destination
        run(3'd3, 3'd4, 3'd3, 5'b00011, 8'h77, "R9");
        run(3'd1, 3'd1, 3'd1, 5'b11111, 8'h77, "R9");
        run(3'd6, 3'd2, 3'd6, 5'b01001, 8'h77, "R9");
        // R4: write into one register leaves others; R10 add to self
        run(3'd6, 3'd6, 3'd6, 5'b00010, 8'h00, "R10");
        run(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R4");
        // R1: mid-run reset
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 1; i <= 7; i++) model[i] = '0;
        run(3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, "R1");
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule